// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor word-wide access to a local packet buffer through one 16-bit data port. The host loads a 16-bit buffer address and a 16-bit byte count, each as a pair of byte registers. It then picks a transfer direction in the command register. From then on, each read or write of the data port moves one word between the port and the buffer, and the engine advances the address and reduces the count. When the count is used up, the engine raises a completion flag in an interrupt status register, and that flag can drive the interrupt output.

The same register window holds the transmit set-up registers: a start page and a 16-bit frame length. A command bit starts transmission. This block does not serialise the frame. An external sender reads the page, length and busy outputs, then returns a one-cycle `tx_done` pulse. That pulse clears the busy bit and raises a transmit-complete flag. Bits 7:6 of the command register select a register page. The set-up, status and mask registers can be reached only on page 0. The command register and the data port can be reached on every page.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `tx_busy` is low, and `host_rdata` is zero.
- R2: On page 0, offsets 0x01/0x02 hold the low/high byte of the buffer address and offsets 0x03/0x04 hold the low/high byte of the byte count. Each write takes `host_wdata[7:0]`. A read returns the current value, zero-extended.
- R3: Each accepted data-port access (offset 0x10) moves two bytes when the count is 2 or more, and one byte when the count is 1. The address goes up by the number of bytes moved, and the count goes down by the same number.
- R4: Command bits 4:3 select the direction. The value 10 writes: `host_wdata[7:0]` goes to the buffer at the address and `host_wdata[15:8]` goes to address+1. The value 01 reads: the data port returns the byte at the address in bits 7:0 and the byte at address+1 in bits 15:8.
- R5: When the count is 1, the access moves only the low byte. A read returns zero in bits 15:8, and a write leaves the byte at address+1 unchanged.
- R6: A data-port access is ignored if the direction field is 00 or 11, if the access does not match the direction, or if the count is zero. It reads as zero and changes neither the address nor the count.
- R7: The access that brings the count to zero sets bit 6 of the status register at offset 0x08. Writing 1 to a status bit clears it, and writing 0 leaves it alone. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: `irq` is high exactly when some status bit and its mask bit, at the same position of the mask register at offset 0x09, are both 1.
- R9: Offset 0x05 holds the transmit page, and offsets 0x06/0x07 hold the low/high byte of the transmit length. Both drive `tx_page` and `tx_len`. Writing the command register with bit 2 = 1 sets `tx_busy`. A `tx_done` pulse while busy clears `tx_busy` and sets status bit 1. A `tx_done` pulse while idle has no effect.
- R10: Offsets 0x01 to 0x09 can be reached only when command bits 7:6 are 00. On any other page, writes to those offsets are ignored and reads of them return zero.
- R11: A read of the command register at offset 0x00 returns the page in bits 7:6, the direction in bits 4:3 and `tx_busy` in bit 2. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 5 | Register offset |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 16 | Write data; registers take bits 7:0 |
| host_rdata | output | 16 | Read data, valid in the cycle of `host_rd` |
| tx_done | input | 1 | One-cycle pulse from the frame sender |
| tx_page | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit length in bytes |
| tx_busy | output | 1 | Transmit command pending |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle. One is the final data-port word that ends a transfer. The other is the sender's `tx_done` pulse, and both must leave their own status bit set. The bench drives these together. It also drives `tx_done` in the same cycle as a write-1-to-clear of the transmit bit, and judges the status register read back afterwards: both flags must be present, because a set wins over a clear. Random transfers of odd and even lengths are compared against a byte-level model of the buffer kept in the bench.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CMD     = 5'h00;
    localparam logic [REG_AW-1:0] OFS_ADR_LO  = 5'h01;
    localparam logic [REG_AW-1:0] OFS_ADR_HI  = 5'h02;
    localparam logic [REG_AW-1:0] OFS_CNT_LO  = 5'h03;
    localparam logic [REG_AW-1:0] OFS_CNT_HI  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_TXPG    = 5'h05;
    localparam logic [REG_AW-1:0] OFS_TXLEN_LO = 5'h06;
    localparam logic [REG_AW-1:0] OFS_TXLEN_HI = 5'h07;
    localparam logic [REG_AW-1:0] OFS_STAT    = 5'h08;
    localparam logic [REG_AW-1:0] OFS_MASK    = 5'h09;
    localparam logic [REG_AW-1:0] OFS_PORT    = 5'h10;

    localparam int STAT_XFER_DONE = 6;
    localparam int STAT_TX_DONE   = 1;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'b00,
        DIR_READ  = 2'b01,
        DIR_WRITE = 2'b10,
        DIR_RSVD  = 2'b11
    } dma_dir_e;

    typedef struct packed {
        logic [1:0]  page;
        dma_dir_e    dir;
        logic        tx_go;
        logic [15:0] adr;
        logic [15:0] cnt;
        logic [7:0]  txpg;
        logic [15:0] txlen;
    } ctrl_state_t;

    typedef struct packed {
        logic [7:0] stat;
        logic [7:0] mask;
    } irq_state_t;
endpackage

// File: rtl/rdma_buffer.sv
module rdma_buffer #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] addr_nx;

    assign addr_nx = addr + AW'(1);
    assign rdata   = {mem[addr_nx], mem[addr]};

    always_ff @(posedge clk) begin
        if (we_lo) mem[addr]    <= wdata[7:0];
        if (we_hi) mem[addr_nx] <= wdata[15:8];
    end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [15:0]       host_wdata,
    input  logic              tx_done,
    output logic              page0,
    output logic [7:0]        reg_rd,
    output logic              step,
    output logic              single,
    output logic              port_rd_ok,
    output logic              xfer_fin,
    output logic              tx_fin,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we_lo,
    output logic              buf_we_hi,
    output logic [15:0]       adr_o,
    output logic [15:0]       cnt_o,
    output logic [7:0]        tx_page,
    output logic [15:0]       tx_len,
    output logic              tx_busy
);
    ctrl_state_t st_d, st_q;
    logic        port_hit, wr_ok, rd_ok, cmd_wr;
    logic [15:0] moved;
    logic [7:0]  wb;

    assign wb       = host_wdata[7:0];
    assign page0    = (st_q.page == 2'b00);
    assign port_hit = (host_addr == OFS_PORT) && (st_q.cnt != 16'd0);
    assign wr_ok    = host_wr && port_hit && (st_q.dir == DIR_WRITE);
    assign rd_ok    = host_rd && port_hit && (st_q.dir == DIR_READ);
    assign step     = wr_ok || rd_ok;
    assign single   = (st_q.cnt == 16'd1);
    assign moved    = single ? 16'd1 : 16'd2;
    assign cmd_wr   = host_wr && (host_addr == OFS_CMD);

    assign port_rd_ok = rd_ok;
    assign xfer_fin   = step && (st_q.cnt <= 16'd2);
    assign tx_fin     = tx_done && st_q.tx_go;
    assign buf_addr   = st_q.adr[AW-1:0];
    assign buf_we_lo  = wr_ok;
    assign buf_we_hi  = wr_ok && !single;
    assign adr_o      = st_q.adr;
    assign cnt_o      = st_q.cnt;
    assign tx_page    = st_q.txpg;
    assign tx_len     = st_q.txlen;
    assign tx_busy    = st_q.tx_go;

    always_comb begin
        st_d = st_q;
        if (tx_fin) st_d.tx_go = 1'b0;
        if (cmd_wr) begin
            st_d.page = wb[7:6];
            st_d.dir  = dma_dir_e'(wb[4:3]);
            if (wb[2]) st_d.tx_go = 1'b1;
        end
        if (step) begin
            st_d.adr = st_q.adr + moved;
            st_d.cnt = st_q.cnt - moved;
        end
        if (host_wr && page0) begin
            case (host_addr)
                OFS_ADR_LO:   st_d.adr[7:0]    = wb;
                OFS_ADR_HI:   st_d.adr[15:8]   = wb;
                OFS_CNT_LO:   st_d.cnt[7:0]    = wb;
                OFS_CNT_HI:   st_d.cnt[15:8]   = wb;
                OFS_TXPG:     st_d.txpg        = wb;
                OFS_TXLEN_LO: st_d.txlen[7:0]  = wb;
                OFS_TXLEN_HI: st_d.txlen[15:8] = wb;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rd = 8'h00;
        if (host_addr == OFS_CMD) begin
            reg_rd = {st_q.page, 1'b0, st_q.dir, st_q.tx_go, 2'b00};
        end else if (page0) begin
            case (host_addr)
                OFS_ADR_LO:   reg_rd = st_q.adr[7:0];
                OFS_ADR_HI:   reg_rd = st_q.adr[15:8];
                OFS_CNT_LO:   reg_rd = st_q.cnt[7:0];
                OFS_CNT_HI:   reg_rd = st_q.cnt[15:8];
                OFS_TXPG:     reg_rd = st_q.txpg;
                OFS_TXLEN_LO: reg_rd = st_q.txlen[7:0];
                OFS_TXLEN_HI: reg_rd = st_q.txlen[15:8];
                default:      reg_rd = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/rdma_irq.sv
module rdma_irq
    import rdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic       mask_wr,
    input  logic [7:0] wbyte,
    input  logic       set_xfer,
    input  logic       set_tx,
    output logic [7:0] stat,
    output logic [7:0] mask,
    output logic       irq
);
    irq_state_t st_d, st_q;
    logic [7:0] set_vec;

    always_comb begin
        set_vec = 8'h00;
        set_vec[STAT_XFER_DONE] = set_xfer;
        set_vec[STAT_TX_DONE]   = set_tx;
    end

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.stat = st_q.stat & ~wbyte;
        st_d.stat = st_d.stat | set_vec;
        if (mask_wr) st_d.mask = wbyte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
    assign irq  = |(st_q.stat & st_q.mask);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int BUF_AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        tx_done,
    output logic [7:0]  tx_page,
    output logic [15:0] tx_len,
    output logic        tx_busy,
    output logic        irq
);
    logic              page0, step_w, single, port_rd_ok, xfer_fin, tx_fin;
    logic              we_lo, we_hi;
    logic [7:0]        reg_rd, isr_w, imr_w;
    logic [BUF_AW-1:0] buf_addr;
    logic [15:0]       buf_rd, rsa_w, rbc_w;

    rdma_ctrl #(.AW(BUF_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .tx_done    (tx_done),
        .page0      (page0),
        .reg_rd     (reg_rd),
        .step       (step_w),
        .single     (single),
        .port_rd_ok (port_rd_ok),
        .xfer_fin   (xfer_fin),
        .tx_fin     (tx_fin),
        .buf_addr   (buf_addr),
        .buf_we_lo  (we_lo),
        .buf_we_hi  (we_hi),
        .adr_o      (rsa_w),
        .cnt_o      (rbc_w),
        .tx_page    (tx_page),
        .tx_len     (tx_len),
        .tx_busy    (tx_busy)
    );

    rdma_buffer #(.AW(BUF_AW)) u_buf (
        .clk   (clk),
        .addr  (buf_addr),
        .we_lo (we_lo),
        .we_hi (we_hi),
        .wdata (host_wdata),
        .rdata (buf_rd)
    );

    rdma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (host_wr && page0 && (host_addr == OFS_STAT)),
        .mask_wr  (host_wr && page0 && (host_addr == OFS_MASK)),
        .wbyte    (host_wdata[7:0]),
        .set_xfer (xfer_fin),
        .set_tx   (tx_fin),
        .stat     (isr_w),
        .mask     (imr_w),
        .irq      (irq)
    );

    always_comb begin
        host_rdata = 16'h0000;
        if (host_rd) begin
            if (host_addr == OFS_PORT) begin
                if (port_rd_ok) host_rdata = {single ? 8'h00 : buf_rd[15:8], buf_rd[7:0]};
            end else if (page0 && host_addr == OFS_STAT) begin
                host_rdata = {8'h00, isr_w};
            end else if (page0 && host_addr == OFS_MASK) begin
                host_rdata = {8'h00, imr_w};
            end else begin
                host_rdata = {8'h00, reg_rd};
            end
        end
    end
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  host_addr,
    input logic        host_wr,
    input logic        host_rd,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic        tx_done,
    input logic        tx_busy,
    input logic        irq,
    input logic        step_w,
    input logic [15:0] rsa_w,
    input logic [15:0] rbc_w,
    input logic [7:0]  isr_w,
    input logic [7:0]  imr_w
);
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && rbc_w >= 16'd2) |=> (rbc_w == $past(rbc_w) - 16'd2) && (rsa_w == $past(rsa_w) + 16'd2));

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && rbc_w <= 16'd2) |=> isr_w[6]);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !step_w) |=> ($stable(rbc_w) && $stable(rsa_w)));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 5'h10 && !step_w) |-> (host_rdata == 16'h0000));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_w == 8'h00) |-> !irq);

    assert_tx_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_done && !(host_wr && host_addr == 5'h00 && host_wdata[2])) |=> (!tx_busy && isr_w[1]));
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (.*);

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        tx_done = 1'b0;
    logic [7:0]  tx_page;
    logic [15:0] tx_len;
    logic        tx_busy;
    logic        irq;

    int tests = 0;
    int fails = 0;
    logic [7:0] mdl [1024];

    always #2.5 clk = ~clk;

    rdma_port_engine uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic setup(input logic [15:0] adr, input logic [15:0] cnt, input logic [7:0] cmd);
        wr(5'h01, {8'h0, adr[7:0]});  wr(5'h02, {8'h0, adr[15:8]});
        wr(5'h03, {8'h0, cnt[7:0]});  wr(5'h04, {8'h0, cnt[15:8]});
        wr(5'h00, {8'h0, cmd});
    endtask

    function automatic logic [15:0] exp_word(input int a, input int left);
        return {left >= 2 ? mdl[(a + 1) % 1024] : 8'h00, mdl[a % 1024]};
    endfunction

    task automatic port_write(input int a, input int left, input logic [15:0] d);
        wr(5'h10, d);
        mdl[a % 1024] = d[7:0];
        if (left >= 2) mdl[(a + 1) % 1024] = d[15:8];
    endtask

    task automatic block_write(input int a, input int n);
        setup(16'(a), 16'(n), 8'h10);
        for (int i = 0; i < n; i += 2) port_write(a + i, n - i, 16'($urandom));
    endtask

    task automatic block_check(input int a, input int n, input string tag);
        logic [15:0] v;
        setup(16'(a), 16'(n), 8'h08);
        for (int i = 0; i < n; i += 2) begin
            rd(5'h10, v);
            chk(tag, v, exp_word(a + i, n - i));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 tx_busy", tx_busy, 0);
        chk("R1 rdata idle", host_rdata, 0);
        rd(5'h00, v); chk("R1 cmd", v, 0);
        rd(5'h03, v); chk("R1 cnt lo", v, 0);
        rd(5'h08, v); chk("R1 stat", v, 0);

        // R2 address and count readback
        setup(16'h1234, 16'h0506, 8'h00);
        rd(5'h01, v); chk("R2 adr lo", v, 16'h0034);
        rd(5'h02, v); chk("R2 adr hi", v, 16'h0012);
        rd(5'h03, v); chk("R2 cnt lo", v, 16'h0006);
        rd(5'h04, v); chk("R2 cnt hi", v, 16'h0005);

        // R3 R4 write then read an even block
        block_write(16'h0100, 6);
        rd(5'h01, v); chk("R3 adr after write", v, 16'h0006);
        rd(5'h03, v); chk("R3 cnt after write", v, 0);
        rd(5'h08, v); chk("R7 done flag", v[6], 1);
        block_check(16'h0100, 6, "R4 read word");
        rd(5'h01, v); chk("R3 adr after read", v, 16'h0006);

        // R5 odd final access
        block_write(16'h0200, 6);
        block_write(16'h0200, 5);
        block_check(16'h0200, 6, "R5 high byte kept");
        block_check(16'h0200, 5, "R5 single byte read");
        rd(5'h01, v); chk("R5 adr odd advance", v, 16'h0005);

        // R6 ignored accesses
        setup(16'h0300, 16'd4, 8'h00);
        wr(5'h10, 16'hBEEF);
        rd(5'h10, v); chk("R6 no dir read", v, 0);
        rd(5'h03, v); chk("R6 cnt held", v, 16'h0004);
        wr(5'h00, 16'h0008);
        wr(5'h10, 16'hBEEF);
        rd(5'h01, v); chk("R6 mismatch dir", v, 16'h0000);
        setup(16'h0100, 16'd0, 8'h08);
        rd(5'h10, v); chk("R6 zero cnt read", v, 0);
        rd(5'h01, v); chk("R6 adr held", v, 0);

        // R7 write-one-to-clear
        wr(5'h08, 16'h0000);
        rd(5'h08, v); chk("R7 zero write keeps", v, 16'h0040);
        wr(5'h08, 16'h0040);
        rd(5'h08, v); chk("R7 clear", v, 0);

        // R9 transmit set-up and completion
        wr(5'h05, 16'h0040); wr(5'h06, 16'h003C); wr(5'h07, 16'h0001);
        #1 chk("R9 tx_page", tx_page, 8'h40);
        chk("R9 tx_len", tx_len, 16'h013C);
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        rd(5'h08, v); chk("R9 idle done ignored", v, 0);
        wr(5'h00, 16'h0004);
        #1 chk("R9 busy set", tx_busy, 1);
        rd(5'h00, v); chk("R11 cmd readback", v, 16'h0004);
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        #1 chk("R9 busy clear", tx_busy, 0);
        rd(5'h08, v); chk("R9 tx flag", v, 16'h0002);
        wr(5'h08, 16'h00FF);

        // collision: last word and tx_done in one cycle
        setup(16'h0040, 16'd2, 8'h14);
        @(negedge clk);
        host_addr = 5'h10; host_wdata = 16'hA55A; host_wr = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tx_done = 1'b0;
        mdl[16'h40] = 8'h5A; mdl[16'h41] = 8'hA5;
        rd(5'h08, v); chk("R7 R9 both flags", v, 16'h0042);
        block_check(16'h0040, 2, "R4 collision word");
        // set beats clear on the same bit
        wr(5'h00, 16'h0004);
        @(negedge clk);
        host_addr = 5'h08; host_wdata = 16'h0002; host_wr = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tx_done = 1'b0;
        rd(5'h08, v); chk("R7 set wins", v, 16'h0042);

        // R8 masking
        #1 chk("R8 masked", irq, 0);
        wr(5'h09, 16'h0002);
        #1 chk("R8 unmasked", irq, 1);
        wr(5'h08, 16'h0002);
        #1 chk("R8 other bit masked", irq, 0);
        wr(5'h09, 16'h0040);
        #1 chk("R8 done bit", irq, 1);
        wr(5'h08, 16'h0040);

        // R10 pages, R11 readback
        wr(5'h01, 16'h0077);
        wr(5'h00, 16'h0048);
        rd(5'h00, v); chk("R11 page readback", v, 16'h0048);
        wr(5'h01, 16'h0099);
        rd(5'h01, v); chk("R10 other page read", v, 0);
        rd(5'h09, v); chk("R10 mask hidden", v, 0);
        wr(5'h00, 16'h0000);
        rd(5'h01, v); chk("R10 page0 kept", v, 16'h0077);

        // random transfers
        for (int k = 0; k < 24; k++) begin
            int a, n;
            a = int'($urandom_range(0, 1023));
            n = int'($urandom_range(1, 17));
            block_write(a, n);
            rd(5'h03, v); chk("R3 random cnt", v, 0);
            rd(5'h08, v); chk("R7 random flag", v[6], 1);
            wr(5'h08, 16'h0040);
            block_check(a, n, "R4 random read");
            rd(5'h01, v); chk("R3 random adr", v, 16'((a + n) & 16'h00FF));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule